// File: doc/BRIEF.md
# DRAM Self-Refresh Entry and Exit Sequencer

This block moves a low-power asynchronous DRAM into self-refresh when the system asks to sleep, and brings it back out when the system wakes. First it has the refresh scheduler run one ordinary distributed refresh. Then it takes the memory bus through the same request/grant handshake that the scheduler uses. It pulls the column strobes low ahead of the row strobe to start a column-before-row refresh cycle, and keeps the row strobe low well past the point where the device switches to its internal refresh.

On wake, the block raises the column strobes a short, bounded time before the row strobe, as the device's negative column hold rule allows. It keeps the row strobe high for the longer precharge that self-refresh exit needs. It then returns the bus and has the scheduler run one more refresh at once, so that a refresh falls on both sides of the sleep period. Write enable and output enable stay inactive (high) throughout.

A wake request that arrives before the minimum row-strobe low time has passed is latched. The exit then starts as soon as the minimum is met. A wake request that arrives while the block is idle has no effect.

Top module: `dram_selfref_seq`

## Requirements
- R1: While reset is held, ras_n, cas_lo_n, cas_hi_n, we_n and oe_n are high, and bus_req, ref_req, sr_ack and wake_done are low.
- R2: A sleep_req sampled while idle raises ref_req on the next cycle. ref_req stays high, and the strobes and bus_req stay inactive, until ref_ack is sampled high.
- R3: The cycle after ref_ack is sampled, ref_req falls and bus_req rises. Both column strobes and ras_n stay high while bus_gnt is low, and any strobe low implies bus_req high.
- R4: The cycle after bus_gnt is sampled, both column strobes go low. ras_n goes low CSR_CYC+1 cycles after that, and sr_ack rises in the same cycle as ras_n falls.
- R5: While sr_ack is high, ras_n and both column strobes are low. ras_n stays low for at least HOLD_MIN_CYC cycles.
- R6: Exit starts (column strobes rise) in the later of two cycles: the cycle after a wake_req is sampled, or HOLD_MIN_CYC+1 cycles after ras_n fell. A wake_req sampled at any time after sleep was accepted is remembered until it is used.
- R7: sr_ack falls together with the column strobes. ras_n rises exactly CAS_LEAD_CYC+1 cycles after the column strobes rise.
- R8: ras_n stays high for PRECH_CYC+1 cycles. Then bus_req falls and ref_req rises in the same cycle.
- R9: The cycle after ref_ack is sampled in the post-exit refresh, ref_req falls and wake_done is high for exactly one cycle. ref_req is never high while ras_n is low.
- R10: we_n and oe_n are high in every cycle.
- R11: A wake_req sampled while idle is discarded. It does not shorten the next self-refresh period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | Request to enter self-refresh, sampled while idle |
| wake_req | input | 1 | Request to leave self-refresh |
| ref_ack | input | 1 | Refresh scheduler has finished the requested refresh |
| bus_gnt | input | 1 | Bus grant from the access arbiter |
| ref_req | output | 1 | Ask the refresh scheduler for one distributed refresh |
| bus_req | output | 1 | Bus ownership request |
| ras_n | output | 1 | Row strobe, active low |
| cas_lo_n | output | 1 | Lower byte column strobe, active low |
| cas_hi_n | output | 1 | Upper byte column strobe, active low |
| we_n | output | 1 | Write enable, held high |
| oe_n | output | 1 | Output enable, held high |
| sr_ack | output | 1 | Device is in the self-refresh hold |
| wake_done | output | 1 | One-cycle pulse when the wake sequence is complete |

## Verification
Two events can land in the same cycle: the hold timer running out and a wake request being sampled. In that cycle, either the direct wake path or the latched-wake path could start the exit. The bench places a single-cycle wake pulse exactly at the minimum-hold boundary, one cycle before it, and one cycle after it. It also sends a wake pulse during the pre-entry refresh. In each case it compares the cycle in which the column strobes rise with the later of the wake cycle plus one and the row-strobe fall plus HOLD_MIN_CYC+1. An early or late exit, or a lost wake, shows up as a different cycle number.

// File: rtl/sr_seq_pkg.sv
package sr_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_PRE_REF  = 3'd1,
        ST_ENTER    = 3'd2,
        ST_HOLD     = 3'd3,
        ST_EXIT_PRE = 3'd4,
        ST_POST_REF = 3'd5,
        ST_DONE     = 3'd6
    } sr_state_e;

    // Registered sequencer state; every strobe leaves the block from a flop.
    typedef struct packed {
        sr_state_e st;
        logic      sub;        // second phase inside ENTER / EXIT_PRE
        logic      ras_n;
        logic      cas_n;
        logic      bus_req;
        logic      ref_req;
        logic      sr_ack;
        logic      wake_done;
    } sr_regs_t;

    localparam sr_regs_t SR_REGS_RST = '{
        st:        ST_IDLE,
        sub:       1'b0,
        ras_n:     1'b1,
        cas_n:     1'b1,
        bus_req:   1'b0,
        ref_req:   1'b0,
        sr_ack:    1'b0,
        wake_done: 1'b0
    };

endpackage

// File: rtl/sr_cycle_timer.sv
module sr_cycle_timer #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    output logic             expired
);

    logic [WIDTH-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

    // R5: once the window has run out it stays run out until reloaded
    p_expiry_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !load) |=> expired);

    // R4: a nonzero load starts a window that has not yet run out
    p_load_arms_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_val != '0) |=> !expired);

endmodule

// File: rtl/sr_wake_latch.sv
module sr_wake_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic wake_req,
    output logic pending
);

    logic pend_d, pend_q;

    always_comb begin
        pend_d = arm & (pend_q | wake_req);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= pend_d;
        end
    end

    assign pending = arm & (pend_q | wake_req);

    // R6: a seen wake is not forgotten while the sequence is still armed
    p_wake_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && wake_req) |=> (pending || !arm));

    // R11: nothing is remembered across an unarmed cycle
    p_idle_discard_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !arm |=> (pend_q == 1'b0));

endmodule

// File: rtl/dram_selfref_seq.sv
module dram_selfref_seq
    import sr_seq_pkg::*;
#(
    parameter int HOLD_MIN_CYC = 25000,  // minimum row-strobe low time in clocks
    parameter int CSR_CYC      = 2,      // column-before-row setup, in clocks
    parameter int CAS_LEAD_CYC = 1,      // column release ahead of row release
    parameter int PRECH_CYC    = 20      // extended exit precharge, in clocks
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_req,
    input  logic wake_req,
    input  logic ref_ack,
    input  logic bus_gnt,
    output logic ref_req,
    output logic bus_req,
    output logic ras_n,
    output logic cas_lo_n,
    output logic cas_hi_n,
    output logic we_n,
    output logic oe_n,
    output logic sr_ack,
    output logic wake_done
);

    localparam int PH_MAX_A = (CSR_CYC > CAS_LEAD_CYC) ? CSR_CYC : CAS_LEAD_CYC;
    localparam int PH_MAX   = (PH_MAX_A > PRECH_CYC) ? PH_MAX_A : PRECH_CYC;
    localparam int PH_W     = $clog2(PH_MAX + 1) < 1 ? 1 : $clog2(PH_MAX + 1);
    localparam int HOLD_W   = $clog2(HOLD_MIN_CYC + 1) < 1 ? 1 : $clog2(HOLD_MIN_CYC + 1);

    sr_regs_t          r_d, r_q;
    logic              ph_load, hold_load;
    logic [PH_W-1:0]   ph_val;
    logic              ph_expired, hold_expired;
    logic              wake_pending, wake_arm;

    // One timer handles the short phases; one handles the long hold window.
    sr_cycle_timer #(.WIDTH(PH_W)) u_phase_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ph_load),
        .load_val (ph_val),
        .expired  (ph_expired)
    );

    sr_cycle_timer #(.WIDTH(HOLD_W)) u_hold_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (hold_load),
        .load_val (HOLD_W'(HOLD_MIN_CYC)),
        .expired  (hold_expired)
    );

    assign wake_arm = (r_q.st != ST_IDLE) && (r_q.st != ST_DONE);

    sr_wake_latch u_wake_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (wake_arm),
        .wake_req (wake_req),
        .pending  (wake_pending)
    );

    always_comb begin
        r_d         = r_q;
        r_d.wake_done = 1'b0;
        ph_load     = 1'b0;
        ph_val      = '0;
        hold_load   = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (sleep_req) begin
                    r_d.st      = ST_PRE_REF;
                    r_d.ref_req = 1'b1;
                end
            end
            ST_PRE_REF: begin
                if (ref_ack) begin
                    r_d.ref_req = 1'b0;
                    r_d.bus_req = 1'b1;
                    r_d.sub     = 1'b0;
                    r_d.st      = ST_ENTER;
                end
            end
            ST_ENTER: begin
                if (!r_q.sub) begin
                    if (bus_gnt) begin
                        r_d.cas_n = 1'b0;
                        r_d.sub   = 1'b1;
                        ph_load   = 1'b1;
                        ph_val    = PH_W'(CSR_CYC);
                    end
                end else if (ph_expired) begin
                    r_d.ras_n  = 1'b0;
                    r_d.sr_ack = 1'b1;
                    hold_load  = 1'b1;
                    r_d.st     = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (hold_expired && wake_pending) begin
                    r_d.cas_n  = 1'b1;
                    r_d.sr_ack = 1'b0;
                    r_d.sub    = 1'b0;
                    ph_load    = 1'b1;
                    ph_val     = PH_W'(CAS_LEAD_CYC);
                    r_d.st     = ST_EXIT_PRE;
                end
            end
            ST_EXIT_PRE: begin
                if (!r_q.sub) begin
                    if (ph_expired) begin
                        r_d.ras_n = 1'b1;
                        r_d.sub   = 1'b1;
                        ph_load   = 1'b1;
                        ph_val    = PH_W'(PRECH_CYC);
                    end
                end else if (ph_expired) begin
                    r_d.bus_req = 1'b0;
                    r_d.ref_req = 1'b1;
                    r_d.sub     = 1'b0;
                    r_d.st      = ST_POST_REF;
                end
            end
            ST_POST_REF: begin
                if (ref_ack) begin
                    r_d.ref_req   = 1'b0;
                    r_d.wake_done = 1'b1;
                    r_d.st        = ST_DONE;
                end
            end
            ST_DONE: begin
                r_d.st = ST_IDLE;
            end
            default: begin
                r_d = SR_REGS_RST;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= SR_REGS_RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign ras_n     = r_q.ras_n;
    assign cas_lo_n  = r_q.cas_n;
    assign cas_hi_n  = r_q.cas_n;
    assign bus_req   = r_q.bus_req;
    assign ref_req   = r_q.ref_req;
    assign sr_ack    = r_q.sr_ack;
    assign wake_done = r_q.wake_done;
    assign we_n      = 1'b1;
    assign oe_n      = 1'b1;

    // ---------------- checks on strobe timing ----------------
    logic [HOLD_W:0] ras_lo_cnt_q;
    logic [PH_W:0]   ras_hi_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ras_lo_cnt_q <= '0;
            ras_hi_cnt_q <= '0;
        end else begin
            if (ras_n) begin
                ras_lo_cnt_q <= '0;
                if (ras_hi_cnt_q <= (PH_W+1)'(PRECH_CYC)) ras_hi_cnt_q <= ras_hi_cnt_q + 1'b1;
            end else begin
                ras_hi_cnt_q <= '0;
                if (ras_lo_cnt_q <= (HOLD_W+1)'(HOLD_MIN_CYC)) ras_lo_cnt_q <= ras_lo_cnt_q + 1'b1;
            end
        end
    end

    p_ack_strobes_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sr_ack |-> (!ras_n && !cas_lo_n && !cas_hi_n));

    p_cas_before_ras_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (!cas_lo_n && $past(!cas_lo_n)));

    p_cas_leads_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> (cas_lo_n && $past(cas_lo_n)));

    p_strobes_own_bus_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n || !cas_lo_n) |-> bus_req);

    p_hold_length_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> (ras_lo_cnt_q >= (HOLD_W+1)'(HOLD_MIN_CYC)));

    p_precharge_length_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_req) |-> (ras_hi_cnt_q > (PH_W+1)'(PRECH_CYC)));

    p_no_ref_in_sr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(ref_req && !ras_n));

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wake_done |=> !wake_done);

    p_cas_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cas_lo_n == cas_hi_n);

endmodule

// File: tb/tb_dram_selfref_seq.sv
module tb_dram_selfref_seq;

    localparam int H    = 40;
    localparam int CSR  = 2;
    localparam int LEAD = 1;
    localparam int PRE  = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_req = 1'b0, wake_req = 1'b0, ref_ack = 1'b0, bus_gnt = 1'b0;
    logic ref_req, bus_req, ras_n, cas_lo_n, cas_hi_n, we_n, oe_n, sr_ack, wake_done;

    dram_selfref_seq #(
        .HOLD_MIN_CYC (H),
        .CSR_CYC      (CSR),
        .CAS_LEAD_CYC (LEAD),
        .PRECH_CYC    (PRE)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep_req (sleep_req),
        .wake_req  (wake_req),
        .ref_ack   (ref_ack),
        .bus_gnt   (bus_gnt),
        .ref_req   (ref_req),
        .bus_req   (bus_req),
        .ras_n     (ras_n),
        .cas_lo_n  (cas_lo_n),
        .cas_hi_n  (cas_hi_n),
        .we_n      (we_n),
        .oe_n      (oe_n),
        .sr_ack    (sr_ack),
        .wake_done (wake_done)
    );

    always #2 clk = ~clk;   // 250 MHz

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int errors = 0;
    int bad_en = 0;

    always @(negedge clk) begin
        if (rst_n && (we_n !== 1'b1 || oe_n !== 1'b1)) bad_en++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // gd: grant delay, ad: pre-refresh ack delay, wo: wake offset from RAS fall,
    // rd: post-refresh ack delay, early: wake sent during pre-entry refresh
    task automatic run_seq(input int gd, input int ad, input int wo, input int rd,
                           input bit early, output int hold_len);
        int s_s, s_g, t_rf, s_w, t_cr, t_rr, t_pr, g, exp_cr;
        @(negedge clk);
        sleep_req = 1'b1;
        s_s = cyc;
        @(negedge clk);
        sleep_req = 1'b0;
        chk(ref_req === 1'b1 && cyc == s_s + 1, "R2 pre-entry refresh request", ref_req, 1);
        for (int i = 0; i < ad; i++) begin
            if (early && i == 0) wake_req = 1'b1;
            @(negedge clk);
            wake_req = 1'b0;
            chk(ras_n === 1'b1 && cas_lo_n === 1'b1 && bus_req === 1'b0 && ref_req === 1'b1,
                "R2 idle strobes before ack", ras_n, 1);
        end
        ref_ack = 1'b1;
        @(negedge clk);
        ref_ack = 1'b0;
        chk(bus_req === 1'b1 && ref_req === 1'b0, "R3 bus request after ack", bus_req, 1);
        for (int i = 0; i < gd; i++) begin
            @(negedge clk);
            chk(cas_lo_n === 1'b1 && cas_hi_n === 1'b1 && ras_n === 1'b1,
                "R3 no strobe without grant", cas_lo_n, 1);
        end
        bus_gnt = 1'b1;
        s_g = cyc;
        @(negedge clk);
        chk(cas_lo_n === 1'b0 && cas_hi_n === 1'b0 && ras_n === 1'b1,
            "R4 column strobes first", cas_lo_n, 0);
        g = 0;
        while (ras_n !== 1'b0 && g < 100) begin @(negedge clk); g++; end
        t_rf = cyc;
        chk(t_rf == s_g + CSR + 2, "R4 row strobe fall cycle", t_rf - s_g, CSR + 2);
        chk(sr_ack === 1'b1, "R4 ack with row strobe", sr_ack, 1);
        if (!early) begin
            while (cyc < t_rf + wo) @(negedge clk);
            chk(sr_ack === 1'b1, "R5 ack held before wake", sr_ack, 1);
            wake_req = 1'b1;
            s_w = cyc;
            @(negedge clk);
            wake_req = 1'b0;
            exp_cr = (s_w + 1 > t_rf + H + 1) ? s_w + 1 : t_rf + H + 1;
        end else begin
            exp_cr = t_rf + H + 1;
        end
        g = 0;
        while (cas_lo_n !== 1'b1 && g < 4 * H + 200) begin @(negedge clk); g++; end
        t_cr = cyc;
        hold_len = t_cr - t_rf;
        chk(t_cr == exp_cr, "R6 exit start cycle", t_cr - t_rf, exp_cr - t_rf);
        chk(t_cr - t_rf > H, "R5 minimum hold", t_cr - t_rf, H + 1);
        chk(sr_ack === 1'b0 && ras_n === 1'b0, "R7 ack drops, row still low", sr_ack, 0);
        g = 0;
        while (ras_n !== 1'b1 && g < 100) begin @(negedge clk); g++; end
        t_rr = cyc;
        chk(t_rr == t_cr + LEAD + 1, "R7 column lead before row", t_rr - t_cr, LEAD + 1);
        g = 0;
        while (ref_req !== 1'b1 && g < 100) begin @(negedge clk); g++; end
        t_pr = cyc;
        chk(t_pr == t_rr + PRE + 1, "R8 extended precharge", t_pr - t_rr, PRE + 1);
        chk(bus_req === 1'b0, "R8 bus released with refresh request", bus_req, 0);
        bus_gnt = 1'b0;
        repeat (rd) @(negedge clk);
        ref_ack = 1'b1;
        @(negedge clk);
        ref_ack = 1'b0;
        chk(wake_done === 1'b1 && ref_req === 1'b0, "R9 done pulse", wake_done, 1);
        @(negedge clk);
        chk(wake_done === 1'b0, "R9 single done pulse", wake_done, 0);
        chk(bad_en == 0, "R10 write and output enables high", bad_en, 0);
    endtask

    localparam int NV = 7;
    localparam int VEC [NV][5] = '{
        '{0, 0, 0,     0, 0},
        '{3, 2, 10,    1, 0},
        '{1, 5, H + 5, 2, 0},
        '{2, 1, H,     0, 0},   // wake lands on the expiry cycle
        '{0, 1, H - 1, 1, 0},   // wake one cycle before expiry
        '{1, 3, 0,     0, 1},   // wake during pre-entry refresh
        '{0, 1, H + 1, 3, 0}    // wake one cycle after expiry
    };

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int hl;
        repeat (3) @(negedge clk);
        chk(ras_n === 1'b1 && cas_lo_n === 1'b1 && cas_hi_n === 1'b1, "R1 strobes high in reset", ras_n, 1);
        chk(we_n === 1'b1 && oe_n === 1'b1, "R1 enables high in reset", we_n, 1);
        chk(bus_req === 1'b0 && ref_req === 1'b0 && sr_ack === 1'b0 && wake_done === 1'b0,
            "R1 requests low in reset", bus_req, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            run_seq(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4] != 0, hl);
            repeat (2) @(negedge clk);
        end

        // R11: wake while idle is dropped and must not shorten the next hold
        wake_req = 1'b1;
        @(negedge clk);
        wake_req = 1'b0;
        repeat (2) @(negedge clk);
        chk(ras_n === 1'b1 && ref_req === 1'b0 && bus_req === 1'b0, "R11 idle wake no action", ras_n, 1);
        run_seq(1, 1, H + 20, 1, 1'b0, hl);
        chk(hl == H + 21, "R11 idle wake not remembered", hl, H + 21);

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule